// File: doc/BRIEF.md
# Legacy I/O Claim Decoder

This block sits on the target side of a PCI-style bus and decides, for every transaction whose address phase it sees, whether to claim it and on which clock after the address phase its device-select strobe fires. Out of reset it claims nothing early: every transaction that no other agent takes is accepted subtractively on the fourth clock and handed on. A control value then lets it claim the low 1 KB I/O window earlier (third or second clock), keep the primary and/or secondary disk-controller port groups out of that early claim, and claim the DMA high-page port range early.

Whatever the timing, an accepted transaction leaves as a one-cycle forward request carrying the captured address, the captured command and a flag telling whether the claim was subtractive. If another agent asserts its device select on a clock before the one this block picked, the block stands back: it neither claims nor forwards.

Top module: `lio_claim_decoder`

## Requirements
- R1: After reset no strobe or forward request is active, and with the control value at zero (speed code 00, all group bits clear) every transaction is claimed on clock 4 after its address phase with the subtractive flag set to 1.
- R2: The early-claim window is I/O addresses 0x000 through 0x3FF inclusive; 0x400 and any address with bits above bit 9 set are claimed subtractively on clock 4.
- R3: The 2-bit speed code sets the claim clock for the window: 00 gives clock 4 (subtractive), 01 gives clock 3, 10 and 11 both give clock 2; the subtractive flag is 0 for clocks 2 and 3.
- R4: With the primary-disk reject bit set, addresses 0x1F0 through 0x1F7 and 0x3F6 are claimed subtractively on clock 4; neighbours such as 0x1F8 keep the early claim.
- R5: With the secondary-disk reject bit set, addresses 0x170 through 0x177 and 0x376 are claimed subtractively on clock 4; neighbours such as 0x178 keep the early claim.
- R6: With the DMA high-page bit set, I/O addresses 0x480 through 0x48F are claimed on clock 2 whatever the speed code; with it clear, or outside that range (0x490), they are claimed on clock 4.
- R7: Only I/O read (command 4'b0010) and I/O write (command 4'b0011) are claimed early; any other command is claimed on clock 4 even inside the window.
- R8: The forward request is valid in exactly the cycle of the claim strobe and carries the address and command captured at the address phase.
- R9: If another agent's device select is seen on a clock earlier than this block's claim clock, the block neither claims nor forwards that transaction; seen on the same clock, the block still claims.
- R10: Each transaction produces at most one claim-strobe cycle, and an address-phase start while a decision is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_speed | input | 2 | Claim speed code for the legacy window |
| cfg_rej_pri | input | 1 | Keep primary disk ports out of early claim |
| cfg_rej_sec | input | 1 | Keep secondary disk ports out of early claim |
| cfg_dma_hi | input | 1 | Claim DMA high-page range on clock 2 |
| adr_start | input | 1 | Address phase present this cycle |
| adr_addr | input | ADDR_W | Address of the address phase |
| adr_cmd | input | CMD_W | Bus command of the address phase |
| devsel_other | input | 1 | Another agent asserts device select this cycle |
| claim_strobe | output | 1 | Device-select strobe, high on the claim clock |
| fwd_vld | output | 1 | Forward request valid |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_cmd | output | CMD_W | Forwarded command |
| fwd_subtr | output | 1 | Forwarded transaction was claimed subtractively |

## Verification
The bench builds the block with its default parameters, a 32-bit address and a 4-bit command. The full address width puts addresses with upper bits set within reach, so the test that the window compares the whole address and not only its low ten bits can be made, and the 4-bit command lets memory commands be shown to fall to subtractive claim. Claim clocks are measured against each speed code, each window edge and each port group edge, and competing device-select timing is swept around the chosen clock.

// File: rtl/lio_pkg.sv
// Shared constants and helpers for the legacy I/O claim decoder.
// Assumes the claim clock never exceeds 4, so a 3-bit count is enough.
package lio_pkg;
    localparam int CLK_W = 3;
    localparam logic [CLK_W-1:0] CLK_MED   = 3'd2;
    localparam logic [CLK_W-1:0] CLK_SLOW  = 3'd3;
    localparam logic [CLK_W-1:0] CLK_SUBTR = 3'd4;

    localparam int CMD_IO_RD = 2;
    localparam int CMD_IO_WR = 3;

    localparam int LEGACY_HI  = 'h3FF;
    localparam int DMAPG_LO   = 'h480;
    localparam int DMAPG_HI   = 'h48F;
    localparam int IDE_CH     = 2;
    localparam int IDE_BLK_SZ = 8;

    typedef enum logic [1:0] {
        SPD_SUBTR = 2'b00,
        SPD_SLOW  = 2'b01,
        SPD_MED   = 2'b10,
        SPD_ALT   = 2'b11
    } speed_e;

    // Base of the eight-port command block of disk channel ch (0 primary).
    function automatic int ide_blk_base(int ch);
        return (ch == 0) ? 'h1F0 : 'h170;
    endfunction

    // Single control port of disk channel ch.
    function automatic int ide_ctl_port(int ch);
        return (ch == 0) ? 'h3F6 : 'h376;
    endfunction

    // Claim clock chosen by the speed code for the legacy window.
    function automatic logic [CLK_W-1:0] speed_clk(speed_e s);
        case (s)
            SPD_SLOW:         return CLK_SLOW;
            SPD_MED, SPD_ALT: return CLK_MED;
            default:          return CLK_SUBTR;
        endcase
    endfunction
endpackage

// File: rtl/lio_range_match.sv
// Inclusive address range comparator [LO, HI] over the full address.
// Assumes LO <= HI; a zero lower bound drops the lower compare.
module lio_range_match #(
    parameter int ADDR_W = 32,
    parameter int LO     = 0,
    parameter int HI     = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LO_V = ADDR_W'(LO);
    localparam logic [ADDR_W-1:0] HI_V = ADDR_W'(HI);

    generate
        if (LO == 0) begin : g_upper_only
            // compare against the top of the range only
            assign hit = (addr <= HI_V);
        end else if (LO == HI) begin : g_single
            // a one-port range is an equality test
            assign hit = (addr == LO_V);
        end else begin : g_both
            // both bounds inclusive
            assign hit = (addr >= LO_V) && (addr <= HI_V);
        end
    endgenerate
endmodule

// File: rtl/lio_addr_decode.sv
// Combinational claim-clock selection for one address phase.
// Assumes control inputs are stable during the address phase cycle.
module lio_addr_decode
    import lio_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input  logic [1:0]        cfg_speed,
    input  logic              cfg_rej_pri,
    input  logic              cfg_rej_sec,
    input  logic              cfg_dma_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    output logic [CLK_W-1:0]  claim_clk
);
    logic              legacy_hit;
    logic              dmapg_hit;
    logic [IDE_CH-1:0] ide_hit;
    logic [IDE_CH-1:0] ide_rej;
    logic              ide_veto;
    logic              is_io;

    lio_range_match #(.ADDR_W(ADDR_W), .LO(0), .HI(LEGACY_HI)) u_legacy (
        .addr (addr),
        .hit  (legacy_hit)
    );

    lio_range_match #(.ADDR_W(ADDR_W), .LO(DMAPG_LO), .HI(DMAPG_HI)) u_dmapg (
        .addr (addr),
        .hit  (dmapg_hit)
    );

    generate
        for (genvar ch = 0; ch < IDE_CH; ch++) begin : g_ide
            logic blk_hit;
            logic port_hit;

            lio_range_match #(
                .ADDR_W (ADDR_W),
                .LO     (ide_blk_base(ch)),
                .HI     (ide_blk_base(ch) + IDE_BLK_SZ - 1)
            ) u_blk (
                .addr (addr),
                .hit  (blk_hit)
            );

            lio_range_match #(
                .ADDR_W (ADDR_W),
                .LO     (ide_ctl_port(ch)),
                .HI     (ide_ctl_port(ch))
            ) u_port (
                .addr (addr),
                .hit  (port_hit)
            );

            // a channel's group is the command block plus its control port
            assign ide_hit[ch] = blk_hit | port_hit;
        end
    endgenerate

    assign ide_rej  = {cfg_rej_sec, cfg_rej_pri};
    assign ide_veto = |(ide_hit & ide_rej);
    assign is_io    = (cmd == CMD_W'(CMD_IO_RD)) || (cmd == CMD_W'(CMD_IO_WR));

    // pick the claim clock: DMA page first, then the legacy window, else subtractive
    always_comb begin
        claim_clk = CLK_SUBTR;
        if (is_io && cfg_dma_hi && dmapg_hit) begin
            claim_clk = CLK_MED;
        end else if (is_io && legacy_hit && !ide_veto) begin
            claim_clk = speed_clk(speed_e'(cfg_speed));
        end
    end
endmodule

// File: rtl/lio_claim_timer.sv
// Counts clocks after an accepted address phase and fires the claim on
// the selected clock, unless another agent claims on an earlier clock.
// Assumes one outstanding transaction; starts while busy are dropped.
module lio_claim_timer
    import lio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CLK_W-1:0] claim_clk,
    input  logic             devsel_other,
    output logic             busy,
    output logic [CLK_W-1:0] cnt,
    output logic [CLK_W-1:0] tgt,
    output logic             claim
);
    logic early_other;

    assign early_other = devsel_other && (cnt < tgt);
    assign claim       = busy && (cnt == tgt);

    // track the clock count of the pending decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            tgt  <= CLK_SUBTR;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= CLK_W'(1);
                tgt  <= claim_clk;
            end
        end else if (claim || early_other) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + CLK_W'(1);
        end
    end
endmodule

// File: rtl/lio_claim_decoder.sv
// Top of the legacy I/O claim decoder: captures the address phase,
// selects the claim clock, drives the device-select strobe and the
// forward request. Assumes the bus protocol keeps address phases apart
// by at least the claim window.
module lio_claim_decoder
    import lio_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_speed,
    input  logic              cfg_rej_pri,
    input  logic              cfg_rej_sec,
    input  logic              cfg_dma_hi,
    input  logic              adr_start,
    input  logic [ADDR_W-1:0] adr_addr,
    input  logic [CMD_W-1:0]  adr_cmd,
    input  logic              devsel_other,
    output logic              claim_strobe,
    output logic              fwd_vld,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [CMD_W-1:0]  fwd_cmd,
    output logic              fwd_subtr
);
    logic [CLK_W-1:0] dec_clk;
    logic             t_busy;
    logic [CLK_W-1:0] t_cnt;
    logic [CLK_W-1:0] t_tgt;
    logic             t_claim;
    logic             accept;

    assign accept = adr_start && !t_busy;

    lio_addr_decode #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_dec (
        .cfg_speed   (cfg_speed),
        .cfg_rej_pri (cfg_rej_pri),
        .cfg_rej_sec (cfg_rej_sec),
        .cfg_dma_hi  (cfg_dma_hi),
        .addr        (adr_addr),
        .cmd         (adr_cmd),
        .claim_clk   (dec_clk)
    );

    lio_claim_timer u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (adr_start),
        .claim_clk    (dec_clk),
        .devsel_other (devsel_other),
        .busy         (t_busy),
        .cnt          (t_cnt),
        .tgt          (t_tgt),
        .claim        (t_claim)
    );

    // hold the address and command of the accepted address phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_addr <= '0;
            fwd_cmd  <= '0;
        end else if (accept) begin
            fwd_addr <= adr_addr;
            fwd_cmd  <= adr_cmd;
        end
    end

    assign claim_strobe = t_claim;
    assign fwd_vld      = t_claim;
    assign fwd_subtr    = (t_tgt == CLK_SUBTR);
endmodule

// Temporal checks on the decoder's ports and timer state.
module lio_claim_decoder_chk
    import lio_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              devsel_other,
    input logic              claim_strobe,
    input logic              fwd_vld,
    input logic [ADDR_W-1:0] fwd_addr,
    input logic              fwd_subtr,
    input logic              t_busy,
    input logic [CLK_W-1:0]  t_cnt
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !t_busy |-> !fwd_vld);

    a_r1_subtr_on_clock4: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_strobe && fwd_subtr) |-> (t_cnt == CLK_SUBTR));

    a_r3_early_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_strobe && !fwd_subtr) |-> (t_cnt == CLK_MED || t_cnt == CLK_SLOW));

    a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_vld && $past(t_busy)) |-> $stable(fwd_addr));

    a_r9_back_off: assert property (@(posedge clk) disable iff (!rst_n)
        (t_busy && devsel_other && !claim_strobe) |=> !claim_strobe);

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        claim_strobe |=> !claim_strobe);
endmodule

bind lio_claim_decoder lio_claim_decoder_chk #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .devsel_other (devsel_other),
    .claim_strobe (claim_strobe),
    .fwd_vld      (fwd_vld),
    .fwd_addr     (fwd_addr),
    .fwd_subtr    (fwd_subtr),
    .t_busy       (t_busy),
    .t_cnt        (t_cnt)
);

// File: tb/lio_claim_decoder_tb_top.sv
module lio_claim_decoder_tb_top;
    localparam int ADDR_W = 32;
    localparam int CMD_W  = 4;
    localparam logic [3:0] C_IORD = 4'b0010;
    localparam logic [3:0] C_IOWR = 4'b0011;
    localparam logic [3:0] C_MRD  = 4'b0110;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_speed = 2'b00;
    logic              cfg_rej_pri = 1'b0;
    logic              cfg_rej_sec = 1'b0;
    logic              cfg_dma_hi = 1'b0;
    logic              adr_start = 1'b0;
    logic [ADDR_W-1:0] adr_addr = '0;
    logic [CMD_W-1:0]  adr_cmd = '0;
    logic              devsel_other = 1'b0;
    logic              claim_strobe;
    logic              fwd_vld;
    logic [ADDR_W-1:0] fwd_addr;
    logic [CMD_W-1:0]  fwd_cmd;
    logic              fwd_subtr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    lio_claim_decoder #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_speed (cfg_speed), .cfg_rej_pri (cfg_rej_pri),
        .cfg_rej_sec (cfg_rej_sec), .cfg_dma_hi (cfg_dma_hi),
        .adr_start (adr_start), .adr_addr (adr_addr), .adr_cmd (adr_cmd),
        .devsel_other (devsel_other),
        .claim_strobe (claim_strobe), .fwd_vld (fwd_vld),
        .fwd_addr (fwd_addr), .fwd_cmd (fwd_cmd), .fwd_subtr (fwd_subtr)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(logic [1:0] spd, logic rp, logic rs, logic dh);
        @(negedge clk);
        cfg_speed = spd; cfg_rej_pri = rp; cfg_rej_sec = rs; cfg_dma_hi = dh;
    endtask

    // one transaction: measure the claim clock and the forward request
    task automatic run_txn(string req, logic [ADDR_W-1:0] a, logic [CMD_W-1:0] c,
                           int other_clk, int exp_clk);
        int got = 0;
        int n_claim = 0;
        logic [ADDR_W-1:0] ga = '0;
        logic [CMD_W-1:0]  gc = '0;
        logic gs = 1'b0;
        logic vld_ok = 1'b1;
        @(negedge clk);
        adr_start = 1'b1; adr_addr = a; adr_cmd = c; devsel_other = 1'b0;
        @(posedge clk);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            adr_start = 1'b0;
            devsel_other = (k == other_clk);
            if (fwd_vld !== claim_strobe) vld_ok = 1'b0;
            if (claim_strobe === 1'b1) begin
                n_claim++;
                if (got == 0) begin
                    got = k; ga = fwd_addr; gc = fwd_cmd; gs = fwd_subtr;
                end
            end
        end
        devsel_other = 1'b0;
        check(req, "claim clock", got, exp_clk);
        check("R10", "strobe cycles", n_claim, (exp_clk != 0) ? 1 : 0);
        check("R8", "fwd_vld equals strobe", vld_ok, 1);
        if (exp_clk != 0) begin
            check("R8", "fwd_addr", ga, a);
            check("R8", "fwd_cmd", gc, c);
            check(req, "fwd_subtr", gs, (exp_clk == 4) ? 1 : 0);
        end
    endtask

    task automatic t_reset_default();
        @(negedge clk);
        check("R1", "strobe after reset", claim_strobe, 0);
        check("R1", "fwd_vld after reset", fwd_vld, 0);
        set_cfg(2'b00, 0, 0, 0);
        run_txn("R1", 32'h60, C_IORD, 0, 4);
        run_txn("R1", 32'h1F0, C_IOWR, 0, 4);
        run_txn("R1", 32'h480, C_IORD, 0, 4);
    endtask

    task automatic t_window_edges();
        set_cfg(2'b01, 0, 0, 0);
        run_txn("R2", 32'h000, C_IORD, 0, 3);
        run_txn("R2", 32'h3FF, C_IOWR, 0, 3);
        run_txn("R2", 32'h400, C_IORD, 0, 4);
        run_txn("R2", 32'h1000_0060, C_IORD, 0, 4);
    endtask

    task automatic t_speed_codes();
        set_cfg(2'b01, 0, 0, 0); run_txn("R3", 32'h60, C_IORD, 0, 3);
        set_cfg(2'b10, 0, 0, 0); run_txn("R3", 32'h60, C_IORD, 0, 2);
        set_cfg(2'b11, 0, 0, 0); run_txn("R3", 32'h60, C_IOWR, 0, 2);
        set_cfg(2'b00, 0, 0, 0); run_txn("R3", 32'h60, C_IORD, 0, 4);
    endtask

    task automatic t_reject_primary();
        set_cfg(2'b10, 1, 0, 0);
        run_txn("R4", 32'h1F0, C_IORD, 0, 4);
        run_txn("R4", 32'h1F7, C_IOWR, 0, 4);
        run_txn("R4", 32'h3F6, C_IORD, 0, 4);
        run_txn("R4", 32'h1F8, C_IORD, 0, 2);
        run_txn("R4", 32'h170, C_IORD, 0, 2);
        set_cfg(2'b10, 0, 0, 0);
        run_txn("R4", 32'h1F0, C_IORD, 0, 2);
    endtask

    task automatic t_reject_secondary();
        set_cfg(2'b01, 0, 1, 0);
        run_txn("R5", 32'h170, C_IORD, 0, 4);
        run_txn("R5", 32'h177, C_IORD, 0, 4);
        run_txn("R5", 32'h376, C_IOWR, 0, 4);
        run_txn("R5", 32'h178, C_IORD, 0, 3);
        run_txn("R5", 32'h3F6, C_IORD, 0, 3);
    endtask

    task automatic t_dma_page();
        set_cfg(2'b00, 0, 0, 1);
        run_txn("R6", 32'h480, C_IORD, 0, 2);
        run_txn("R6", 32'h48F, C_IOWR, 0, 2);
        run_txn("R6", 32'h490, C_IORD, 0, 4);
        run_txn("R6", 32'h47F, C_IORD, 0, 4);
        set_cfg(2'b01, 0, 0, 0);
        run_txn("R6", 32'h480, C_IORD, 0, 4);
    endtask

    task automatic t_non_io();
        set_cfg(2'b10, 0, 0, 1);
        run_txn("R7", 32'h60, C_MRD, 0, 4);
        run_txn("R7", 32'h480, 4'b0111, 0, 4);
    endtask

    task automatic t_other_agent();
        set_cfg(2'b10, 0, 0, 0);
        run_txn("R9", 32'h60, C_IORD, 1, 0);
        run_txn("R9", 32'h60, C_IORD, 2, 2);
        set_cfg(2'b00, 0, 0, 0);
        run_txn("R9", 32'h60, C_IORD, 3, 0);
        run_txn("R9", 32'h60, C_IORD, 4, 4);
    endtask

    // R10: a start arriving mid-decision is dropped; address stays the first
    task automatic t_start_while_busy();
        int got = 0;
        logic [ADDR_W-1:0] ga = '0;
        set_cfg(2'b00, 0, 0, 0);
        @(negedge clk);
        adr_start = 1'b1; adr_addr = 32'h60; adr_cmd = C_IORD;
        @(posedge clk);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            adr_start = (k == 2);
            adr_addr  = (k == 2) ? 32'h70 : 32'h60;
            if (claim_strobe === 1'b1) begin
                if (got == 0) begin got = k; ga = fwd_addr; end
            end
        end
        adr_start = 1'b0;
        check("R10", "claim clock with late start", got, 4);
        check("R10", "address kept", ga, 32'h60);
        repeat (6) @(negedge clk);
        check("R10", "no second claim", claim_strobe, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_default();
        t_window_edges();
        t_speed_codes();
        t_reject_primary();
        t_reject_secondary();
        t_dma_page();
        t_non_io();
        t_other_agent();
        t_start_while_busy();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule